// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the instruction fetch address of a small 8-bit controller core whose program space is 4K words split into 1K-word pages. Each cycle the decoder presents at most a few strobes describing the current instruction's effect on control flow. The block answers with the next fetch address and a flag telling the fetch stage that a fetched word must be thrown away. The strobes cover sequential stepping, jumps and calls with a 10-bit in-page literal, returns, writes and adds to the low address byte, a table add that keeps the in-page high bits, a hardware interrupt and a software interrupt instruction. The two page bits come from the core's status register.

Calls and the software interrupt push the address of the following instruction onto a five-entry hardware stack. A hardware interrupt pushes the address of the instruction it displaces. Returns pop that stack and restore the whole address, whatever the page bits are. Every change of flow other than a plain step costs two cycles. In the second cycle the flush flag is high, the address holds, and all strobes are ignored.

Top module: `pcseq_top`

## Requirements
- R1: While reset is asserted, and right after it is released, fetchAddr is 0xFFF and flushBusy is 0.
- R2: When no flow-changing strobe is active, fetchAddr increments by 1 (0xFFF wraps to 0x000) if advance is high, and holds otherwise. flushBusy stays 0.
- R3: A jump loads fetchAddr with {pageSel, literal}, with pageSel in bits 11:10.
- R4: A call loads fetchAddr the same way as a jump and pushes the old fetchAddr+1.
- R5: A return loads fetchAddr with the full 12-bit top-of-stack entry and ignores pageSel.
- R6: A low-byte write loads {pageSel, 2'b00, wrLowData}. A low-byte add loads {pageSel, 2'b00, (fetchAddr[7:0]+accum) mod 256}.
- R7: A table add loads {fetchAddr[11:8], (fetchAddr[7:0]+accum) mod 256}, so bits 11:8 are unchanged and the carry is dropped.
- R8: A hardware interrupt loads 0x001 and pushes the current fetchAddr.
- R9: A software interrupt loads 0x002 and pushes fetchAddr+1.
- R10: Every load other than a step or hold raises flushBusy for exactly the next cycle. In that cycle fetchAddr holds and every strobe is ignored.
- R11: The stack holds five entries. A push when it is full overwrites the oldest entry, so the five newest entries pop back in reverse order.
- R12: A pop from an empty stack returns the value of the most recent successful pop (0 if none since reset) and leaves the stack unchanged.
- R13: When several strobes are active together, only one takes effect, in this priority order: hardware interrupt, software interrupt, return, call, jump, table add, low-byte add, low-byte write, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Step to the next sequential word |
| jumpEn | input | 1 | Jump to the in-page literal |
| callEn | input | 1 | Call the in-page literal, pushing the return address |
| literal | input | 10 | In-page target offset |
| retEn | input | 1 | Return from the stack top |
| wrLowEn | input | 1 | Write the low address byte |
| wrLowData | input | 8 | Data for a low-byte write |
| addLowEn | input | 1 | Add accum to the low byte and clear bits 9:8 |
| tableEn | input | 1 | Add accum to the low byte and keep bits 11:8 |
| accum | input | 8 | Accumulator operand |
| irqReq | input | 1 | Hardware interrupt request |
| swIntEn | input | 1 | Software interrupt instruction |
| pageSel | input | 2 | Page bits from the status register |
| fetchAddr | output | 12 | Current fetch address |
| flushBusy | output | 1 | Second cycle of a two-cycle flow change |

## Verification
The collisions that matter most are a hardware interrupt arriving in the same cycle as a call or jump, and any strobe arriving during the flush cycle of an earlier change. Directed cycles raise the interrupt together with a call and a jump. They then check that the target is 0x001 and that a later return yields the displaced address, not that address plus one. Random cycles raise several strobes at once, some of them while flushBusy is high. A reference model in the bench predicts the next address, the flag and the stack contents from the priority list, and each mismatch is reported against the requirement of the strobe that should have won.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [3:0] {
    SEL_HOLD,
    SEL_INC,
    SEL_JUMP,
    SEL_RET,
    SEL_WRLOW,
    SEL_ADDLOW,
    SEL_TABLE,
    SEL_VEC_HW,
    SEL_VEC_SW
  } pcSel_e;

  typedef enum logic [1:0] {
    PUSH_NONE,
    PUSH_NEXT,
    PUSH_CUR
  } pushSrc_e;

  typedef struct packed {
    pcSel_e   pcSel;
    pushSrc_e pushSrc;
    logic     pop;
    logic     startFlush;
  } pcStrobes_t;

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] topData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] prevIdx;
  logic [PTR_W-1:0] nextIdx;
  logic [CNT_W-1:0] fill;
  logic [WIDTH-1:0] lastPop;
  logic             isEmpty;

  assign prevIdx = (wrPtr == '0) ? LAST_IDX : PTR_W'(wrPtr - 1'b1);
  assign nextIdx = (wrPtr == LAST_IDX) ? '0 : PTR_W'(wrPtr + 1'b1);
  assign isEmpty = (fill == '0);
  assign topData = isEmpty ? lastPop : mem[prevIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      fill    <= '0;
      lastPop <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wrPtr] <= pushData;
      wrPtr      <= nextIdx;
      if (fill != FULL_CNT) fill <= CNT_W'(fill + 1'b1);
    end else if (pop && !isEmpty) begin
      wrPtr   <= prevIdx;
      fill    <= CNT_W'(fill - 1'b1);
      lastPop <= mem[prevIdx];
    end
  end

endmodule

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       jumpEn,
  input  logic       callEn,
  input  logic       retEn,
  input  logic       wrLowEn,
  input  logic       addLowEn,
  input  logic       tableEn,
  input  logic       irqReq,
  input  logic       swIntEn,
  output pcStrobes_t ctl,
  output logic       flushBusy
);

  always_comb begin
    ctl.pcSel   = SEL_HOLD;
    ctl.pushSrc = PUSH_NONE;
    ctl.pop     = 1'b0;
    if (!flushBusy) begin
      if (irqReq) begin
        ctl.pcSel   = SEL_VEC_HW;
        ctl.pushSrc = PUSH_CUR;
      end else if (swIntEn) begin
        ctl.pcSel   = SEL_VEC_SW;
        ctl.pushSrc = PUSH_NEXT;
      end else if (retEn) begin
        ctl.pcSel = SEL_RET;
        ctl.pop   = 1'b1;
      end else if (callEn) begin
        ctl.pcSel   = SEL_JUMP;
        ctl.pushSrc = PUSH_NEXT;
      end else if (jumpEn) begin
        ctl.pcSel = SEL_JUMP;
      end else if (tableEn) begin
        ctl.pcSel = SEL_TABLE;
      end else if (addLowEn) begin
        ctl.pcSel = SEL_ADDLOW;
      end else if (wrLowEn) begin
        ctl.pcSel = SEL_WRLOW;
      end else if (advance) begin
        ctl.pcSel = SEL_INC;
      end
    end
    ctl.startFlush = (ctl.pcSel != SEL_HOLD) && (ctl.pcSel != SEL_INC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flushBusy <= 1'b0;
    else        flushBusy <= ctl.startFlush;
  end

endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OFFS_W      = 10,
  parameter int LOW_W       = 8,
  parameter int STACK_DEPTH = 5,
  parameter int HW_VECTOR   = 1,
  parameter int SW_VECTOR   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pcStrobes_t               ctl,
  input  logic [ADDR_W-OFFS_W-1:0] pageSel,
  input  logic [OFFS_W-1:0]        literal,
  input  logic [LOW_W-1:0]         wrLowData,
  input  logic [LOW_W-1:0]         accum,
  output logic [ADDR_W-1:0]        fetchAddr
);
  localparam int PAGE_W = ADDR_W - OFFS_W;
  localparam int MID_W  = OFFS_W - LOW_W;
  localparam int UP_W   = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] pcInc;
  logic [LOW_W-1:0]  lowSum;
  logic [ADDR_W-1:0] stackTop;
  logic [ADDR_W-1:0] pushData;
  logic [ADDR_W-1:0] pcNext;
  logic [MID_W-1:0]  midZero;
  logic [PAGE_W-1:0] pageBits;
  logic [UP_W-1:0]   upperKeep;

  assign pcInc     = ADDR_W'(fetchAddr + 1'b1);
  assign lowSum    = LOW_W'(fetchAddr[LOW_W-1:0] + accum);
  assign midZero   = '0;
  assign pageBits  = pageSel;
  assign upperKeep = fetchAddr[ADDR_W-1:LOW_W];
  assign pushData  = (ctl.pushSrc == PUSH_CUR) ? fetchAddr : pcInc;

  always_comb begin
    unique case (ctl.pcSel)
      SEL_INC:    pcNext = pcInc;
      SEL_JUMP:   pcNext = {pageBits, literal};
      SEL_RET:    pcNext = stackTop;
      SEL_WRLOW:  pcNext = {pageBits, midZero, wrLowData};
      SEL_ADDLOW: pcNext = {pageBits, midZero, lowSum};
      SEL_TABLE:  pcNext = {upperKeep, lowSum};
      SEL_VEC_HW: pcNext = ADDR_W'(HW_VECTOR);
      SEL_VEC_SW: pcNext = ADDR_W'(SW_VECTOR);
      default:    pcNext = fetchAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetchAddr <= '1;
    else        fetchAddr <= pcNext;
  end

  pcseq_stack #(
    .WIDTH (ADDR_W),
    .DEPTH (STACK_DEPTH)
  ) u_retStack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ctl.pushSrc != PUSH_NONE),
    .pushData (pushData),
    .pop      (ctl.pop),
    .topData  (stackTop)
  );

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OFFS_W      = 10,
  parameter int LOW_W       = 8,
  parameter int STACK_DEPTH = 5,
  parameter int HW_VECTOR   = 1,
  parameter int SW_VECTOR   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     advance,
  input  logic                     jumpEn,
  input  logic                     callEn,
  input  logic [OFFS_W-1:0]        literal,
  input  logic                     retEn,
  input  logic                     wrLowEn,
  input  logic [LOW_W-1:0]         wrLowData,
  input  logic                     addLowEn,
  input  logic                     tableEn,
  input  logic [LOW_W-1:0]         accum,
  input  logic                     irqReq,
  input  logic                     swIntEn,
  input  logic [ADDR_W-OFFS_W-1:0] pageSel,
  output logic [ADDR_W-1:0]        fetchAddr,
  output logic                     flushBusy
);

  pcStrobes_t ctl;

  pcseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .jumpEn    (jumpEn),
    .callEn    (callEn),
    .retEn     (retEn),
    .wrLowEn   (wrLowEn),
    .addLowEn  (addLowEn),
    .tableEn   (tableEn),
    .irqReq    (irqReq),
    .swIntEn   (swIntEn),
    .ctl       (ctl),
    .flushBusy (flushBusy)
  );

  pcseq_datapath #(
    .ADDR_W      (ADDR_W),
    .OFFS_W      (OFFS_W),
    .LOW_W       (LOW_W),
    .STACK_DEPTH (STACK_DEPTH),
    .HW_VECTOR   (HW_VECTOR),
    .SW_VECTOR   (SW_VECTOR)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .pageSel   (pageSel),
    .literal   (literal),
    .wrLowData (wrLowData),
    .accum     (accum),
    .fetchAddr (fetchAddr)
  );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int ADDR_W    = 12,
  parameter int OFFS_W    = 10,
  parameter int LOW_W     = 8,
  parameter int HW_VECTOR = 1,
  parameter int SW_VECTOR = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     advance,
  input logic                     jumpEn,
  input logic                     callEn,
  input logic [OFFS_W-1:0]        literal,
  input logic                     retEn,
  input logic                     wrLowEn,
  input logic                     addLowEn,
  input logic                     tableEn,
  input logic                     irqReq,
  input logic                     swIntEn,
  input logic [ADDR_W-OFFS_W-1:0] pageSel,
  input logic [ADDR_W-1:0]        fetchAddr,
  input logic                     flushBusy
);
  logic aboveJump;
  logic anyFlow;
  assign aboveJump = irqReq | swIntEn | retEn | callEn;
  assign anyFlow   = aboveJump | jumpEn | tableEn | addLowEn | wrLowEn;

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flushBusy |=> !flushBusy); // R10

  AST_FLUSH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    flushBusy |=> fetchAddr == $past(fetchAddr)); // R10

  AST_HW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushBusy && irqReq) |=> (fetchAddr == ADDR_W'(HW_VECTOR)) && flushBusy); // R8

  AST_SW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushBusy && !irqReq && swIntEn) |=> fetchAddr == ADDR_W'(SW_VECTOR)); // R9

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushBusy && !aboveJump && jumpEn) |=> fetchAddr == {$past(pageSel), $past(literal)}); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushBusy && !anyFlow && advance) |=>
      (fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1)) && !flushBusy); // R2

  AST_TABLE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushBusy && !aboveJump && !jumpEn && tableEn) |=>
      fetchAddr[ADDR_W-1:LOW_W] == $past(fetchAddr[ADDR_W-1:LOW_W])); // R7

endmodule

bind pcseq_top pcseq_checker #(
  .ADDR_W    (ADDR_W),
  .OFFS_W    (OFFS_W),
  .LOW_W     (LOW_W),
  .HW_VECTOR (HW_VECTOR),
  .SW_VECTOR (SW_VECTOR)
) u_pcseqChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .advance   (advance),
  .jumpEn    (jumpEn),
  .callEn    (callEn),
  .literal   (literal),
  .retEn     (retEn),
  .wrLowEn   (wrLowEn),
  .addLowEn  (addLowEn),
  .tableEn   (tableEn),
  .irqReq    (irqReq),
  .swIntEn   (swIntEn),
  .pageSel   (pageSel),
  .fetchAddr (fetchAddr),
  .flushBusy (flushBusy)
);

// File: tb/test_pcseq_top.sv
module test_pcseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        advance, jumpEn, callEn, retEn, wrLowEn, addLowEn, tableEn, irqReq, swIntEn;
  logic [9:0]  literal;
  logic [7:0]  wrLowData, accum;
  logic [1:0]  pageSel;
  logic [11:0] fetchAddr;
  logic        flushBusy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] mPc;
  logic        mFlush;
  logic [11:0] mStk [DEPTH];
  int          mPtr, mCnt;
  logic [11:0] mLast;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcseq_top i_pcseq_top (
    .clk(clk), .rst_n(rst_n), .advance(advance), .jumpEn(jumpEn), .callEn(callEn),
    .literal(literal), .retEn(retEn), .wrLowEn(wrLowEn), .wrLowData(wrLowData),
    .addLowEn(addLowEn), .tableEn(tableEn), .accum(accum), .irqReq(irqReq),
    .swIntEn(swIntEn), .pageSel(pageSel), .fetchAddr(fetchAddr), .flushBusy(flushBusy)
  );

  task automatic setIdle();
    {advance, jumpEn, callEn, retEn, wrLowEn, addLowEn, tableEn, irqReq, swIntEn} = '0;
    literal = '0; wrLowData = '0; accum = '0; pageSel = '0;
  endtask

  task automatic check(string tag, logic [11:0] expA, logic expF);
    checks++;
    if (fetchAddr !== expA || flushBusy !== expF) begin
      fails++;
      $display("FAIL %s: fetchAddr=%h flushBusy=%b expected %h/%b", tag, fetchAddr, flushBusy, expA, expF);
    end
  endtask

  task automatic mPush(logic [11:0] v, inout string tag);
    if (mCnt == DEPTH) tag = "R11";
    mStk[mPtr] = v;
    mPtr = (mPtr + 1) % DEPTH;
    if (mCnt < DEPTH) mCnt++;
  endtask

  task automatic mPop(output logic [11:0] v, inout string tag);
    if (mCnt == 0) begin
      v = mLast; tag = "R12";
    end else begin
      mPtr = (mPtr + DEPTH - 1) % DEPTH;
      mCnt--;
      mLast = mStk[mPtr];
      v = mLast;
    end
  endtask

  task automatic modelStep(output string tag);
    int nEn;
    logic [11:0] v;
    nEn = int'(irqReq) + int'(swIntEn) + int'(retEn) + int'(callEn) + int'(jumpEn)
        + int'(tableEn) + int'(addLowEn) + int'(wrLowEn);
    tag = "R2";
    if (mFlush) begin
      mFlush = 1'b0; tag = "R10";
      return;
    end
    mFlush = 1'b1;
    if (irqReq)        begin tag = "R8"; mPush(mPc, tag); mPc = 12'h001; end
    else if (swIntEn)  begin tag = "R9"; mPush(12'(mPc + 1), tag); mPc = 12'h002; end
    else if (retEn)    begin tag = "R5"; mPop(v, tag); mPc = v; end
    else if (callEn)   begin tag = "R4"; mPush(12'(mPc + 1), tag); mPc = {pageSel, literal}; end
    else if (jumpEn)   begin tag = "R3"; mPc = {pageSel, literal}; end
    else if (tableEn)  begin tag = "R7"; mPc = {mPc[11:8], 8'(mPc[7:0] + accum)}; end
    else if (addLowEn) begin tag = "R6"; mPc = {pageSel, 2'b00, 8'(mPc[7:0] + accum)}; end
    else if (wrLowEn)  begin tag = "R6"; mPc = {pageSel, 2'b00, wrLowData}; end
    else begin
      mFlush = 1'b0;
      if (advance) mPc = 12'(mPc + 1);
    end
    if (nEn > 1 || (nEn == 1 && advance)) tag = "R13";
  endtask

  task automatic cycle(string forceTag = "");
    string tag;
    modelStep(tag);
    if (forceTag != "") tag = forceTag;
    @(posedge clk);
    @(negedge clk);
    check(tag, mPc, mFlush);
    setIdle();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    setIdle();
    rst_n = 1'b0;
    mPc = 12'hFFF; mFlush = 1'b0; mPtr = 0; mCnt = 0; mLast = '0;
    for (int i = 0; i < DEPTH; i++) mStk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", 12'hFFF, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 12'hFFF, 1'b0);

    // R2 wrap and hold
    advance = 1'b1; cycle("R2");
    cycle("R2");

    // R11 six calls into a five-deep stack, page bits varied
    for (int i = 0; i < 6; i++) begin
      callEn = 1'b1; literal = 10'(16 * i + 3); pageSel = 2'(i); cycle();
      cycle();
    end
    // R5 returns ignore the page bits; R12 pops past empty
    for (int i = 0; i < 7; i++) begin
      retEn = 1'b1; pageSel = 2'(3 - (i % 4)); cycle();
      cycle();
    end

    // R13 interrupt with call and jump in the same cycle, then R10 strobes during flush
    jumpEn = 1'b1; literal = 10'h155; pageSel = 2'b10; cycle("R3");
    cycle("R10");
    irqReq = 1'b1; callEn = 1'b1; jumpEn = 1'b1; literal = 10'h0AA; cycle("R13");
    jumpEn = 1'b1; literal = 10'h3FF; pageSel = 2'b11; cycle("R10");
    retEn = 1'b1; cycle("R8");
    cycle();

    // R7 table add with carry out of the low byte; R6 add and write
    jumpEn = 1'b1; literal = 10'h3F0; pageSel = 2'b01; cycle("R3");
    cycle();
    tableEn = 1'b1; accum = 8'h20; cycle("R7");
    cycle();
    addLowEn = 1'b1; accum = 8'hF5; pageSel = 2'b10; cycle("R6");
    cycle();
    wrLowEn = 1'b1; wrLowData = 8'h7C; pageSel = 2'b11; cycle("R6");
    cycle();
    swIntEn = 1'b1; cycle("R9");
    cycle();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      advance   = ($urandom_range(0, 99) < 75);
      irqReq    = ($urandom_range(0, 99) < 3);
      swIntEn   = ($urandom_range(0, 99) < 3);
      retEn     = ($urandom_range(0, 99) < 9);
      callEn    = ($urandom_range(0, 99) < 9);
      jumpEn    = ($urandom_range(0, 99) < 5);
      tableEn   = ($urandom_range(0, 99) < 4);
      addLowEn  = ($urandom_range(0, 99) < 4);
      wrLowEn   = ($urandom_range(0, 99) < 4);
      literal   = 10'($urandom);
      wrLowData = 8'($urandom);
      accum     = 8'($urandom);
      pageSel   = 2'($urandom);
      cycle();
    end
    finishRun();
  end

endmodule